// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised number of external interrupt lines and presents each one, after sense detection, masking and routing, to one of several target processors. Every line has its own sense configuration: active level (high or low), rising or falling edge, or both edges. A line that is pending and unmasked raises the output of the one processor it is routed to. It also raises one numbered pin of that processor when its pin route is enabled.

Software drives the block through a plain 32-bit register bus with a one-cycle registered read. Masks change through separate set and clear registers, so no read-modify-write is needed. A single software register can set or clear the pending state of any line. This acknowledges edge interrupts and also allows software-generated interrupts. External inputs are synchronised with two flops before detection.

Top module: `shirq_ctrl`

## Requirements
- R1: Reading byte offset 0x000 returns the configuration word: bits [7:0] hold N_LINES/8 - 1 and bits [15:8] hold N_CPUS - 1. Read data is registered and appears one cycle after the address is presented.
- R2: After the synchronous reset, the mask word (0x00C), trigger word (0x01C) and dual-edge word (0x020) read 0 and the polarity word (0x018) reads all ones over the N_LINES low bits. Each processor route reads 1, meaning processor 0. Each pin route reads 0. No line is pending and every output is low.
- R3: Writing 0x010 sets the mask bits written as 1, and writing 0x014 clears them. Bits written as 0 leave their lines unchanged. A masked line that is pending drives no output.
- R4: With its trigger bit at 0 (level), a line is pending while its synchronised input is 1 when its polarity bit is 1, or 0 when its polarity bit is 0, and no longer than that.
- R5: With its trigger bit at 1 and dual-edge bit at 0, a line latches pending on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. Edges of the other direction are ignored, and the line stays pending until software clears it.
- R6: With trigger and dual-edge bits both at 1, rising and falling edges both latch pending, whatever the polarity bit is.
- R7: A write to 0x004 sets the pending latch of the line numbered in bits [7:0] when bit 31 is 1, and clears it when bit 31 is 0. A line number of N_LINES or more changes nothing. A level line is pending while its latch is set, even with its input inactive.
- R8: Offset 0x008 reads the pending state of all lines, line i in bit i, and reflects pending lines whether or not they are masked.
- R9: The processor route of line i is at 0x180 + 4*i, a one-hot value in bits [N_CPUS-1:0]. A write whose low N_CPUS bits are not exactly one-hot leaves the route unchanged.
- R10: cpu_irq[c] is high one cycle after any line is pending, unmasked and routed to processor c, and low one cycle after none is.
- R11: The pin route of line i is at 0x100 + 4*i, with bit 31 as the enable and bits [PIN_W-1:0] as the pin number. pin_irq[c*N_PINS + p] follows the same rule as cpu_irq[c], restricted to enabled lines routed to pin p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Asynchronous interrupt inputs |
| bus_addr | input | 10 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | N_CPUS | Per-processor interrupt request |
| pin_irq | output | N_CPUS*N_PINS | Per-processor, per-pin request |

## Verification
Some properties are checked by assertions on every cycle. An edge latch holds until a software clear. A software set makes the line pending on the next cycle. The set and clear mask writes affect exactly the bits written as 1. Each line's processor route stays one-hot. A pin request never appears without the request of its processor. The bench alone can show the sense behaviour end to end. It sweeps every line through level high, level low, rising, falling and dual-edge modes. For each mode it checks the pending word, the processor output and the pin output. It also covers rejected route writes, out-of-range software line numbers and masking of a pending line.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int BUS_AW = 10;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CFG   = 10'h000;
  localparam logic [BUS_AW-1:0] OFS_SOFT  = 10'h004;
  localparam logic [BUS_AW-1:0] OFS_PEND  = 10'h008;
  localparam logic [BUS_AW-1:0] OFS_MASK  = 10'h00C;
  localparam logic [BUS_AW-1:0] OFS_MSET  = 10'h010;
  localparam logic [BUS_AW-1:0] OFS_MCLR  = 10'h014;
  localparam logic [BUS_AW-1:0] OFS_POL   = 10'h018;
  localparam logic [BUS_AW-1:0] OFS_TRIG  = 10'h01C;
  localparam logic [BUS_AW-1:0] OFS_DUAL  = 10'h020;

  // Region selectors on address bits [9:7]
  localparam logic [2:0] RGN_PIN = 3'b010;  // 0x100..0x17C
  localparam logic [2:0] RGN_CPU = 3'b011;  // 0x180..0x1FC

  localparam int SOFT_SET_BIT = 31;
  localparam int PIN_EN_BIT   = 31;
endpackage

// File: rtl/shirq_line.sv
module shirq_line (
  input  logic clk,
  input  logic rst,
  input  logic irq_raw,
  input  logic pol_pos,
  input  logic edge_mode,
  input  logic dual_edge,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pending
);
  logic sync1_q, sync2_q, hist_q, lat_q;
  logic active, rise, fall, edge_hit;

  assign active   = pol_pos ? sync2_q : ~sync2_q;
  assign rise     = sync2_q & ~hist_q;
  assign fall     = ~sync2_q & hist_q;
  assign edge_hit = edge_mode & (dual_edge ? (rise | fall) : (pol_pos ? rise : fall));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      sync1_q <= irq_raw;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
      if (edge_hit || sw_set) lat_q <= 1'b1;
      else if (sw_clr)        lat_q <= 1'b0;
    end
  end

  assign pending = edge_mode ? lat_q : (active | lat_q);

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && pending && !sw_clr) |=> (pending || !edge_mode)); // R5
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (rst)
    sw_set |=> pending); // R7
endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
  import shirq_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int N_CPUS  = 2,
  parameter int N_PINS  = 4,
  localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [BUS_AW-1:0]              bus_addr,
  input  logic                           bus_we,
  input  logic [BUS_DW-1:0]              bus_wdata,
  output logic [BUS_DW-1:0]              bus_rdata,
  input  logic [N_LINES-1:0]             pending,
  output logic [N_LINES-1:0]             mask_q,
  output logic [N_LINES-1:0]             pol_q,
  output logic [N_LINES-1:0]             trig_q,
  output logic [N_LINES-1:0]             dual_q,
  output logic [N_LINES-1:0]             soft_set,
  output logic [N_LINES-1:0]             soft_clr,
  output logic [N_LINES-1:0]             pin_en,
  output logic [N_LINES-1:0][PIN_W-1:0]  pin_sel,
  output logic [N_LINES-1:0][N_CPUS-1:0] cpu_sel
);
  logic [LINE_W-1:0] idx;
  logic              idx_ok, hit_pin, hit_cpu, hit_soft;
  logic [N_CPUS-1:0] cpu_w;
  logic              cpu_w_ok;
  logic [BUS_DW-1:0] rd_d;
  logic              unused_bits;

  assign idx      = bus_addr[LINE_W+1:2];
  assign idx_ok   = (int'(bus_addr[6:2]) < N_LINES);
  assign hit_pin  = bus_we && (bus_addr[9:7] == RGN_PIN) && idx_ok;
  assign hit_cpu  = bus_we && (bus_addr[9:7] == RGN_CPU) && idx_ok;
  assign hit_soft = bus_we && (bus_addr == OFS_SOFT);
  assign cpu_w    = bus_wdata[N_CPUS-1:0];
  assign cpu_w_ok = (cpu_w != '0) && ((cpu_w & (cpu_w - 1'b1)) == '0);
  assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_soft
      assign soft_set[g] = hit_soft &&  bus_wdata[SOFT_SET_BIT] && (bus_wdata[7:0] == 8'(g));
      assign soft_clr[g] = hit_soft && !bus_wdata[SOFT_SET_BIT] && (bus_wdata[7:0] == 8'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      pol_q   <= '1;
      trig_q  <= '0;
      dual_q  <= '0;
      pin_en  <= '0;
      pin_sel <= '0;
      cpu_sel <= {N_LINES{N_CPUS'(1)}};
    end else if (bus_we) begin
      if (bus_addr == OFS_MSET) mask_q <= mask_q |  bus_wdata[N_LINES-1:0];
      if (bus_addr == OFS_MCLR) mask_q <= mask_q & ~bus_wdata[N_LINES-1:0];
      if (bus_addr == OFS_POL)  pol_q  <= bus_wdata[N_LINES-1:0];
      if (bus_addr == OFS_TRIG) trig_q <= bus_wdata[N_LINES-1:0];
      if (bus_addr == OFS_DUAL) dual_q <= bus_wdata[N_LINES-1:0];
      if (hit_pin) begin
        pin_en[idx]  <= bus_wdata[PIN_EN_BIT];
        pin_sel[idx] <= bus_wdata[PIN_W-1:0];
      end
      if (hit_cpu && cpu_w_ok) cpu_sel[idx] <= cpu_w;
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == OFS_CFG) begin
      rd_d[7:0]  = 8'(N_LINES / 8 - 1);
      rd_d[15:8] = 8'(N_CPUS - 1);
    end else if (bus_addr == OFS_PEND) rd_d[N_LINES-1:0] = pending;
    else if (bus_addr == OFS_MASK)     rd_d[N_LINES-1:0] = mask_q;
    else if (bus_addr == OFS_POL)      rd_d[N_LINES-1:0] = pol_q;
    else if (bus_addr == OFS_TRIG)     rd_d[N_LINES-1:0] = trig_q;
    else if (bus_addr == OFS_DUAL)     rd_d[N_LINES-1:0] = dual_q;
    else if ((bus_addr[9:7] == RGN_PIN) && idx_ok) begin
      rd_d[PIN_EN_BIT]  = pin_en[idx];
      rd_d[PIN_W-1:0]   = pin_sel[idx];
    end else if ((bus_addr[9:7] == RGN_CPU) && idx_ok) begin
      rd_d[N_CPUS-1:0]  = cpu_sel[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MSET) |=>
      ((mask_q & $past(bus_wdata[N_LINES-1:0])) == $past(bus_wdata[N_LINES-1:0]))); // R3
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_MCLR) |=>
      ((mask_q & $past(bus_wdata[N_LINES-1:0])) == '0)); // R3
endmodule

// File: rtl/shirq_route.sv
module shirq_route #(
  parameter int N_LINES = 16,
  parameter int N_CPUS  = 2,
  parameter int N_PINS  = 4,
  localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_LINES-1:0]             pending,
  input  logic [N_LINES-1:0]             mask_q,
  input  logic [N_LINES-1:0]             pin_en,
  input  logic [N_LINES-1:0][PIN_W-1:0]  pin_sel,
  input  logic [N_LINES-1:0][N_CPUS-1:0] cpu_sel,
  output logic [N_CPUS-1:0]              cpu_irq,
  output logic [N_CPUS*N_PINS-1:0]       pin_irq
);
  logic [N_LINES-1:0]                          live;
  logic [N_CPUS-1:0][N_LINES-1:0]              to_cpu;
  logic [N_CPUS-1:0][N_PINS-1:0][N_LINES-1:0]  to_pin;
  logic [N_CPUS-1:0]                           cpu_d;
  logic [N_CPUS*N_PINS-1:0]                    pin_d;

  assign live = pending & mask_q;

  genvar c, p, i;
  generate
    for (c = 0; c < N_CPUS; c++) begin : g_cpu
      for (i = 0; i < N_LINES; i++) begin : g_line
        assign to_cpu[c][i] = cpu_sel[i][c];
      end
      assign cpu_d[c] = |(live & to_cpu[c]);
      for (p = 0; p < N_PINS; p++) begin : g_pin
        for (i = 0; i < N_LINES; i++) begin : g_pl
          assign to_pin[c][p][i] = cpu_sel[i][c] & pin_en[i] & (pin_sel[i] == PIN_W'(p));
        end
        assign pin_d[c*N_PINS+p] = |(live & to_pin[c][p]);
        AST_PIN_NEEDS_CPU: assert property (@(posedge clk) disable iff (rst)
          pin_irq[c*N_PINS+p] |-> cpu_irq[c]); // R11
      end
    end
    for (i = 0; i < N_LINES; i++) begin : g_chk
      AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot(cpu_sel[i])); // R9
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq <= '0;
      pin_irq <= '0;
    end else begin
      cpu_irq <= cpu_d;
      pin_irq <= pin_d;
    end
  end
endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int N_CPUS  = 2,
  parameter int N_PINS  = 4,
  localparam int PIN_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_LINES-1:0]       irq_in,
  input  logic [BUS_AW-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [BUS_DW-1:0]        bus_wdata,
  output logic [BUS_DW-1:0]        bus_rdata,
  output logic [N_CPUS-1:0]        cpu_irq,
  output logic [N_CPUS*N_PINS-1:0] pin_irq
);
  logic [N_LINES-1:0]             pending, mask_q, pol_q, trig_q, dual_q;
  logic [N_LINES-1:0]             soft_set, soft_clr, pin_en;
  logic [N_LINES-1:0][PIN_W-1:0]  pin_sel;
  logic [N_LINES-1:0][N_CPUS-1:0] cpu_sel;

  shirq_regs #(.N_LINES(N_LINES), .N_CPUS(N_CPUS), .N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pending(pending),
    .mask_q(mask_q), .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q),
    .soft_set(soft_set), .soft_clr(soft_clr), .pin_en(pin_en),
    .pin_sel(pin_sel), .cpu_sel(cpu_sel)
  );

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_line
      shirq_line u_line (
        .clk(clk), .rst(rst), .irq_raw(irq_in[g]), .pol_pos(pol_q[g]),
        .edge_mode(trig_q[g]), .dual_edge(dual_q[g]),
        .sw_set(soft_set[g]), .sw_clr(soft_clr[g]), .pending(pending[g])
      );
    end
  endgenerate

  shirq_route #(.N_LINES(N_LINES), .N_CPUS(N_CPUS), .N_PINS(N_PINS)) u_route (
    .clk(clk), .rst(rst), .pending(pending), .mask_q(mask_q),
    .pin_en(pin_en), .pin_sel(pin_sel), .cpu_sel(cpu_sel),
    .cpu_irq(cpu_irq), .pin_irq(pin_irq)
  );
endmodule

// File: tb/shirq_ctrl_bench.sv
module shirq_ctrl_bench;
  localparam int NL = 8;
  localparam int NC = 2;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq_in = '0;
  logic [9:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;
  logic [NC*NP-1:0] pin_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NL-1:0] pol_w = '1, trig_w = '0, dual_w = '0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  shirq_ctrl #(.N_LINES(NL), .N_CPUS(NC), .N_PINS(NP)) u_shirq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .pin_irq(pin_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // pending bit, processor output and pin output of line l
  task automatic chk_line(input string tag, input int l, input bit on);
    logic [31:0] d;
    int c, p;
    c = l % NC; p = l % NP;
    rd(10'h008, d);
    check({tag, " R8 pend"}, 32'(d[l]), 32'(on));
    check({tag, " R10 cpu_irq"}, 32'(cpu_irq), on ? 32'(1 << c) : 32'd0);
    check({tag, " R11 pin_irq"}, 32'(pin_irq), on ? 32'(1 << (c*NP + p)) : 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    check("R2 cpu_irq", 32'(cpu_irq), 32'd0);
    check("R2 pin_irq", 32'(pin_irq), 32'd0);
    rd(10'h00C, rv); check("R2 mask", rv, 32'd0);
    rd(10'h018, rv); check("R2 pol", rv, 32'hFF);
    rd(10'h01C, rv); check("R2 trig", rv, 32'd0);
    rd(10'h020, rv); check("R2 dual", rv, 32'd0);
    rd(10'h008, rv); check("R2 pend", rv, 32'd0);
    rd(10'h18C, rv); check("R2 route", rv, 32'd1);
    rd(10'h10C, rv); check("R2 pin route", rv, 32'd0);
    // R1 configuration
    rd(10'h000, rv); check("R1 cfg", rv, 32'h0000_0100);
    // R3 mask set
    wr(10'h010, 32'hFF);
    rd(10'h00C, rv); check("R3 mask set", rv, 32'hFF);
    // R7 out-of-range software line
    wr(10'h004, 32'h8000_0008); settle();
    rd(10'h008, rv); check("R7 out of range", rv, 32'd0);
    check("R7 out of range cpu", 32'(cpu_irq), 32'd0);

    for (int l = 0; l < NL; l++) begin
      int c;
      c = l % NC;
      // R9 route to processor c, R11 pin l%NP
      wr(10'h180 + 10'(4*l), 32'(1 << c));
      wr(10'h100 + 10'(4*l), 32'h8000_0000 | 32'(l % NP));
      rd(10'h180 + 10'(4*l), rv); check("R9 route", rv, 32'(1 << c));
      wr(10'h180 + 10'(4*l), 32'h3);
      rd(10'h180 + 10'(4*l), rv); check("R9 non-onehot ignored", rv, 32'(1 << c));
      wr(10'h180 + 10'(4*l), 32'h0);
      rd(10'h180 + 10'(4*l), rv); check("R9 zero ignored", rv, 32'(1 << c));

      // R4 level high
      irq_in[l] = 1'b1; settle(); chk_line("R4 level high on", l, 1'b1);
      irq_in[l] = 1'b0; settle(); chk_line("R4 level high off", l, 1'b0);
      // R4 level low
      irq_in[l] = 1'b1; pol_w[l] = 1'b0; wr(10'h018, 32'(pol_w));
      settle(); chk_line("R4 level low idle", l, 1'b0);
      irq_in[l] = 1'b0; settle(); chk_line("R4 level low on", l, 1'b1);
      irq_in[l] = 1'b1; settle(); chk_line("R4 level low off", l, 1'b0);
      // R5 rising edge
      pol_w[l] = 1'b1; trig_w[l] = 1'b1;
      wr(10'h018, 32'(pol_w)); wr(10'h01C, 32'(trig_w));
      irq_in[l] = 1'b0; settle(); chk_line("R5 rise ignores fall", l, 1'b0);
      irq_in[l] = 1'b1; settle(); chk_line("R5 rise latched", l, 1'b1);
      irq_in[l] = 1'b0; settle(); chk_line("R5 rise sticky", l, 1'b1);
      wr(10'h004, 32'(l)); settle(); chk_line("R5 R7 soft clear", l, 1'b0);
      // R5 falling edge
      pol_w[l] = 1'b0; wr(10'h018, 32'(pol_w));
      irq_in[l] = 1'b1; settle(); chk_line("R5 fall ignores rise", l, 1'b0);
      irq_in[l] = 1'b0; settle(); chk_line("R5 fall latched", l, 1'b1);
      wr(10'h004, 32'(l)); settle(); chk_line("R5 fall cleared", l, 1'b0);
      // R6 dual edge, polarity left at 0
      dual_w[l] = 1'b1; wr(10'h020, 32'(dual_w));
      irq_in[l] = 1'b1; settle(); chk_line("R6 dual rise", l, 1'b1);
      wr(10'h004, 32'(l)); settle(); chk_line("R6 dual clear", l, 1'b0);
      irq_in[l] = 1'b0; settle(); chk_line("R6 dual fall", l, 1'b1);
      wr(10'h004, 32'(l)); settle(); chk_line("R6 dual clear2", l, 1'b0);
      // back to level, active high
      pol_w[l] = 1'b1; trig_w[l] = 1'b0; dual_w[l] = 1'b0;
      wr(10'h018, 32'(pol_w)); wr(10'h01C, 32'(trig_w)); wr(10'h020, 32'(dual_w));
      // R7 software set on an idle level line
      wr(10'h004, 32'h8000_0000 | 32'(l)); settle(); chk_line("R7 soft set", l, 1'b1);
      // R3 masking a pending line
      wr(10'h014, 32'(1 << l));
      rd(10'h00C, rv); check("R3 mask clear", rv, 32'hFF & ~32'(1 << l));
      settle();
      check("R3 masked cpu_irq", 32'(cpu_irq), 32'd0);
      rd(10'h008, rv); check("R8 pend while masked", 32'(rv[l]), 32'd1);
      wr(10'h010, 32'(1 << l)); settle(); chk_line("R3 unmasked", l, 1'b1);
      // R11 pin route disabled
      wr(10'h100 + 10'(4*l), 32'(l % NP)); settle();
      check("R11 pin disabled", 32'(pin_irq), 32'd0);
      check("R10 cpu with pin off", 32'(cpu_irq), 32'(1 << c));
      wr(10'h004, 32'(l)); settle(); chk_line("R7 soft clear level", l, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule